// File: doc/BRIEF.md
# Modem Line Status Tracker

This block watches four active-low handshake inputs of a serial port (carrier detect, ring indicator, data set ready, clear to send) and presents them to the CPU as one 8-bit read-only status byte. The upper nibble gives the current asserted level of each line. The lower nibble holds sticky flags that record a change on each line since the CPU last read the byte. Reading the byte clears those flags. While any flag is set, an interrupt request is raised toward the priority logic.

For self-test, a loopback control swaps the pins for four modem-control output bits, so software can exercise the status path without a cable. A hold output serves hardware flow control. When flow control is enabled and clear to send is not asserted, it tells the transmitter not to start another character. It changes only while the transmitter is idle, so the character already being sent always completes.

The pins pass through a synchronizer before edge detection. The status levels shown are the detection history, so a read always returns the state from before any change detected in the same cycle.

Top module: `modem_status_reg`

## Requirements
- R1: Outside loopback, status bits 7, 6, 5 and 4 are the inverse of dcd_ni, ri_ni, dsr_ni and cts_ni. A pin change shows in status_o after the third rising clock edge.
- R2: With loopback_i high, bits 7, 6, 5 and 4 follow out2_i, out1_i, dtr_i and rts_i, and the pins are ignored. The change shows after one clock edge.
- R3: Flags at bits 3 (carrier), 1 (data set ready) and 0 (clear to send) set when their level bit (7, 5, 4) changes in either direction.
- R4: The ring flag at bit 2 sets only when status bit 6 goes from 0 to 1. A 1-to-0 transition leaves it at 0.
- R5: A cycle with rd_i high clears all four flags at the next edge when no change occurs in that cycle.
- R6: If a change is detected in the same cycle as a read, the read returns the pre-change byte and the new flag is still set afterwards.
- R7: irq_o is high exactly when any of status bits 3..0 is 1, and it stays high until a read.
- R8: During and after reset, all flags are 0, and no flag is raised for the pin levels present when reset is released.
- R9: Turning loopback on or off counts as a level change, and sets flags exactly as a line transition would.
- R10: With flow_en_i high, tx_hold_o rises when status bit 4 is 0 and falls when it returns to 1. It updates only in cycles where tx_busy_i is low, one edge after the status bit.
- R11: With flow_en_i low, tx_hold_o goes low at the next idle cycle, whatever clear to send is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dcd_ni | input | 1 | Carrier detect pin, active low |
| ri_ni | input | 1 | Ring indicator pin, active low |
| dsr_ni | input | 1 | Data set ready pin, active low |
| cts_ni | input | 1 | Clear to send pin, active low |
| loopback_i | input | 1 | Take the levels from the control outputs instead of the pins |
| out2_i | input | 1 | Control output looped to the carrier bit |
| out1_i | input | 1 | Control output looped to the ring bit |
| dtr_i | input | 1 | Control output looped to the data set ready bit |
| rts_i | input | 1 | Control output looped to the clear to send bit |
| rd_i | input | 1 | CPU read strobe for the status byte |
| status_o | output | 8 | Status byte: levels in 7..4, change flags in 3..0 |
| irq_o | output | 1 | Modem-status interrupt request |
| flow_en_i | input | 1 | Hardware flow control enable |
| tx_busy_i | input | 1 | Transmitter is in the middle of a character |
| tx_hold_o | output | 1 | Do not start a new character |

## Verification
The two functions that can fall in the same cycle are the clear-on-read and the setting of a change flag. The bench provokes this by raising rd_i in the same cycle as the edge that detects a loopback transition. It samples the byte during the read, expecting the pre-change levels and clear flags, and then expects the new flag to survive the clear. A similar overlap between a clear to send transition and a busy transmitter is judged by holding tx_busy_i high across the transition and expecting tx_hold_o not to move until the transmitter goes idle.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NUM_LINES = 4;
  // index inside a line nibble, matching status bit order 7..4 / 3..0
  localparam int IDX_DCD = 3;
  localparam int IDX_RI  = 2;
  localparam int IDX_DSR = 1;
  localparam int IDX_CTS = 0;

  typedef logic [NUM_LINES-1:0] line_vec_t;

  typedef struct packed {
    line_vec_t level;
    line_vec_t flag;
  } status_byte_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_change_det.sv
module msr_change_det
  import msr_pkg::*;
#(
  parameter int PRIME_CYCLES = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t level_i,
  input  logic      rd_i,
  output line_vec_t level_q_o,
  output line_vec_t flags_o
);
  localparam int CW = $clog2(PRIME_CYCLES + 1);
  localparam logic [CW-1:0] PRIME_MAX = CW'(PRIME_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          primed;
  line_vec_t     prev_q, flag_q, evt;

  assign primed = (cnt_q == PRIME_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!primed) cnt_q <= cnt_q + 1'b1;
  end

  // ring flag reacts to the rising level only; others to any change
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_evt
    if (i == IDX_RI) begin : g_rise
      assign evt[i] = primed & level_i[i] & ~prev_q[i];
    end else begin : g_any
      assign evt[i] = primed & (level_i[i] ^ prev_q[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= level_i;
      if (!primed)   flag_q <= '0;
      else if (rd_i) flag_q <= evt;
      else           flag_q <= flag_q | evt;
    end
  end

  assign level_q_o = prev_q;
  assign flags_o   = flag_q;

  // R8
  prime_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed |=> flag_q == '0);
  // R5
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && level_i == prev_q) |=> flag_q == '0);
  // R6
  rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && primed && level_i[IDX_CTS] != prev_q[IDX_CTS]) |=> flag_q[IDX_CTS]);
  // R4
  ri_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[IDX_RI]) |-> $rose(prev_q[IDX_RI]));
endmodule

// File: rtl/msr_tx_gate.sv
module msr_tx_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flow_en_i,
  input  logic cts_i,
  input  logic tx_busy_i,
  output logic tx_hold_o
);
  logic hold_q;

  // only move at a character boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= 1'b0;
    else if (!tx_busy_i) hold_q <= flow_en_i & ~cts_i;
  end

  assign tx_hold_o = hold_q;

  // R10
  hold_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> $stable(hold_q));
  // R11
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flow_en_i && !tx_busy_i) |=> !hold_q);
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dcd_ni,
  input  logic       ri_ni,
  input  logic       dsr_ni,
  input  logic       cts_ni,
  input  logic       loopback_i,
  input  logic       out2_i,
  input  logic       out1_i,
  input  logic       dtr_i,
  input  logic       rts_i,
  input  logic       rd_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  input  logic       flow_en_i,
  input  logic       tx_busy_i,
  output logic       tx_hold_o
);
  localparam int PRIME_CYCLES = SYNC_STAGES + 1;

  line_vec_t    pins_n, pins_sync_n, loop_lvl, level, lvl_q, flags;
  status_byte_t stat;

  assign pins_n   = {dcd_ni, ri_ni, dsr_ni, cts_ni};
  assign loop_lvl = {out2_i, out1_i, dtr_i, rts_i};

  msr_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_n),
    .q_o   (pins_sync_n)
  );

  assign level = loopback_i ? loop_lvl : ~pins_sync_n;

  msr_change_det #(
    .PRIME_CYCLES(PRIME_CYCLES)
  ) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (level),
    .rd_i     (rd_i),
    .level_q_o(lvl_q),
    .flags_o  (flags)
  );

  msr_tx_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flow_en_i(flow_en_i),
    .cts_i    (lvl_q[IDX_CTS]),
    .tx_busy_i(tx_busy_i),
    .tx_hold_o(tx_hold_o)
  );

  assign stat.level = lvl_q;
  assign stat.flag  = flags;
  assign status_o   = stat;
  assign irq_o      = |flags;

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_i) |=> irq_o);
  // R2
  loop_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loopback_i && $past(loopback_i)) |-> status_o[7:4] == $past(loop_lvl));
endmodule

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dcd_ni = 1'b1, ri_ni = 1'b1, dsr_ni = 1'b1, cts_ni = 1'b1;
  logic loopback_i = 1'b0;
  logic out2_i = 1'b0, out1_i = 1'b0, dtr_i = 1'b0, rts_i = 1'b0;
  logic rd_i = 1'b0, flow_en_i = 1'b0, tx_busy_i = 1'b0;
  logic [7:0] status_o;
  logic irq_o, tx_hold_o;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  modem_status_reg dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dcd_ni(dcd_ni), .ri_ni(ri_ni), .dsr_ni(dsr_ni), .cts_ni(cts_ni),
    .loopback_i(loopback_i),
    .out2_i(out2_i), .out1_i(out1_i), .dtr_i(dtr_i), .rts_i(rts_i),
    .rd_i(rd_i), .status_o(status_o), .irq_o(irq_o),
    .flow_en_i(flow_en_i), .tx_busy_i(tx_busy_i), .tx_hold_o(tx_hold_o)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] lvl);
    {dcd_ni, ri_ni, dsr_ni, cts_ni} = ~lvl;
  endtask

  task automatic set_loop(input logic [3:0] lvl);
    {out2_i, out1_i, dtr_i, rts_i} = lvl;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_i = 1'b1;
    v = status_o;
    cyc(1);
    rd_i = 1'b0;
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] f;
    f = a ^ b;
    f[2] = b[2] & ~a[2];
    return f;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    // R8 reset state with active pins
    set_pins(4'hF);
    cyc(3);
    check("R8 reset status", status_o, 8'h00);
    check("R8 reset hold", {7'd0, tx_hold_o}, 8'h00);
    rst_ni = 1'b1;
    cyc(8);
    check("R8 no false change", status_o, 8'hF0);
    check("R8 irq idle", {7'd0, irq_o}, 8'h00);

    // R1 R3 R4 R5 R7 normal-mode sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_pins(a[3:0]);
        cyc(4);
        do_read(rv);
        set_pins(b[3:0]);
        cyc(3);
        check("R1 R3 R4 pin sweep", status_o, {b[3:0], exp_flags(a[3:0], b[3:0])});
        check("R7 irq pin sweep", {7'd0, irq_o}, {7'd0, |exp_flags(a[3:0], b[3:0])});
      end
    end
    do_read(rv);
    cyc(1);
    check("R5 read clears", status_o, {4'h0, 4'h0} | {status_o[7:4], 4'h0});

    // R9 loopback switch as change; pins now at level 0xF from sweep end
    set_pins(4'h0);
    cyc(4);
    do_read(rv);
    set_loop(4'hF);
    loopback_i = 1'b1;
    cyc(1);
    check("R9 loop on", status_o, 8'hFF);
    do_read(rv);
    check("R5 read returns flags", rv, 8'hFF);
    check("R5 cleared", status_o, 8'hF0);
    check("R7 irq cleared", {7'd0, irq_o}, 8'h00);
    loopback_i = 1'b0;
    cyc(1);
    check("R9 loop off", status_o, 8'h0B);
    do_read(rv);
    loopback_i = 1'b1;

    // R2 loopback sweep; pins held at a conflicting pattern
    set_pins(4'h5);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        set_loop(a[3:0]);
        cyc(1);
        do_read(rv);
        set_loop(b[3:0]);
        cyc(1);
        check("R2 R3 R4 loop sweep", status_o, {b[3:0], exp_flags(a[3:0], b[3:0])});
      end
    end

    // R6 change coincident with read
    set_loop(4'h0);
    cyc(2);
    do_read(rv);
    set_loop(4'h1);
    rd_i = 1'b1;
    rv = status_o;
    cyc(1);
    rd_i = 1'b0;
    check("R6 read sees old", rv, 8'h00);
    check("R6 flag kept", status_o, 8'h11);
    check("R7 irq after overlap", {7'd0, irq_o}, 8'h01);

    // R10 flow control
    flow_en_i = 1'b1;
    set_loop(4'h0);
    cyc(2);
    check("R10 hold on", {7'd0, tx_hold_o}, 8'h01);
    tx_busy_i = 1'b1;
    set_loop(4'h1);
    cyc(3);
    check("R10 hold frozen busy", {7'd0, tx_hold_o}, 8'h01);
    tx_busy_i = 1'b0;
    cyc(1);
    check("R10 hold release", {7'd0, tx_hold_o}, 8'h00);
    tx_busy_i = 1'b1;
    set_loop(4'h0);
    cyc(3);
    check("R10 no hold mid char", {7'd0, tx_hold_o}, 8'h00);
    tx_busy_i = 1'b0;
    cyc(1);
    check("R10 hold at boundary", {7'd0, tx_hold_o}, 8'h01);
    // R11
    flow_en_i = 1'b0;
    cyc(1);
    check("R11 flow off", {7'd0, tx_hold_o}, 8'h00);
    cyc(3);
    check("R11 stays off", {7'd0, tx_hold_o}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule